// File: doc/BRIEF.md
# Shifted-Operand Accumulator Add/Subtract Unit

This block is the accumulator arithmetic stage of a fixed-point signal-processing datapath. It holds two 40-bit accumulators, A and B, and a carry flag. Each accumulator has 8 guard bits above a 16-bit high half and a 16-bit low half.

On each operation strobe it takes a 16-bit operand and shifts it by a signed amount. The operand comes either from the operand input or from the high half of the accumulator that is not the source. The unit then extends the shifted operand to 40 bits, signed or unsigned depending on the opcode. It adds the result to, or subtracts it from, the selected source accumulator, optionally folding in the carry flag. The result goes to the source accumulator, or to an explicitly named destination.

The unit sits behind instruction decode and operand fetch. Those stages present a fully decoded request for one cycle with `op_valid` high. The result, the updated accumulators and the new carry appear on the outputs one clock later. No saturation is applied: results wrap modulo 2^40.

Top module: `acc_addsub_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both accumulators and `carry` become 0 and `result_valid` becomes 0.
- R2: Opcodes are encoded on `op_code` as follows: 0 = add, 1 = subtract, 2 = add with carry, 3 = subtract with borrow, 4 = add unsigned, 5 = subtract unsigned. A strobe with a legal opcode updates `result`, the destination accumulator and `carry` at the next rising edge, and raises `result_valid` for exactly that one cycle.
- R3: `shift_amt` is a 5-bit two's-complement count from -16 to +15. A positive count shifts the extended operand left. A negative count shifts it right: arithmetically for opcodes 0, 1 and 2, and logically for opcodes 3, 4 and 5.
- R4: When `shift_16` is high, the operand is shifted left by exactly 16 and `shift_amt` is ignored.
- R5: Accumulator select 0 means A and 1 means B. If `dst_en` is high, the result is written to the accumulator named by `dst_sel`; otherwise it is written to the one named by `src_sel`. The other accumulator keeps its value.
- R6: Opcode 2 sets the destination to source + shifted operand + carry, using the carry as it stood before the operation.
- R7: Opcode 3 sets the destination to source − zero-extended shifted operand − (1 − carry).
- R8: Opcodes 4 and 5 zero-extend the 16-bit operand before shifting. Opcodes 0, 1 and 2 sign-extend it from bit 15.
- R9: After an add (opcodes 0, 2, 4), `carry` equals the carry out of bit 39. After a subtract (opcodes 1, 3, 5), `carry` is 1 when no borrow occurred and 0 when one did.
- R10: When `opnd_from_acc` is high, the 16-bit operand is bits 31:16 of the accumulator not named by `src_sel`, taken from before the operation.
- R11: In a cycle with `op_valid` low, the accumulators and `carry` keep their values and `result_valid` is 0 at the next edge.
- R12: Opcodes 6 and 7 are reserved. A strobe carrying one of them leaves the accumulators and `carry` unchanged and gives `result_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe, one cycle per request |
| op_code | input | 3 | Operation code (see R2) |
| operand | input | 16 | 16-bit operand from memory or immediate |
| opnd_from_acc | input | 1 | Take the operand from the other accumulator's bits 31:16 |
| shift_amt | input | 5 | Signed shift count, -16 to +15 |
| shift_16 | input | 1 | Force a left shift of 16 |
| src_sel | input | 1 | Source accumulator, 0 = A, 1 = B |
| dst_en | input | 1 | Use `dst_sel` as the destination |
| dst_sel | input | 1 | Explicit destination accumulator, 0 = A, 1 = B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| carry | output | 1 | Carry flag |
| result | output | 40 | Result of the last legal operation |
| result_valid | output | 1 | High for one cycle after a legal operation |

## Verification
Every result of this unit is due exactly one rising edge after the strobe: `result`, `result_valid`, the written accumulator and `carry` all come out of a single register stage. The bench drives each request on a falling edge and holds the strobe for one cycle. It then samples all outputs on the following falling edge, half a period after the updating edge. The bench reruns that same sampling point after idle cycles and after reserved opcodes, to show that nothing moved.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int ACC_W      = 40;
    localparam int OPND_W     = 16;
    localparam int SHIFT_W    = 5;
    localparam int FIXED_SH   = 16;
    localparam int NUM_ACC    = 2;
    localparam int MAG_W      = SHIFT_W + 1;
    localparam int HI_LSB     = OPND_W;
    localparam int HI_MSB     = 2 * OPND_W - 1;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDC = 3'd2,
        OP_SUBB = 3'd3,
        OP_ADDU = 3'd4,
        OP_SUBU = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } acc_op_e;

    typedef logic [ACC_W-1:0] acc_word_t;

    typedef struct packed {
        logic legal;
        logic is_sub;
        logic zero_ext;
        logic use_carry;
    } op_ctrl_t;

    typedef struct packed {
        logic      we;
        logic      idx;
        acc_word_t data;
        logic      carry;
    } acc_wr_t;

    function automatic op_ctrl_t decode_op(input acc_op_e op);
        op_ctrl_t c;
        c = '0;
        case (op)
            OP_ADD:  c = '{legal: 1'b1, is_sub: 1'b0, zero_ext: 1'b0, use_carry: 1'b0};
            OP_SUB:  c = '{legal: 1'b1, is_sub: 1'b1, zero_ext: 1'b0, use_carry: 1'b0};
            OP_ADDC: c = '{legal: 1'b1, is_sub: 1'b0, zero_ext: 1'b0, use_carry: 1'b1};
            OP_SUBB: c = '{legal: 1'b1, is_sub: 1'b1, zero_ext: 1'b1, use_carry: 1'b1};
            OP_ADDU: c = '{legal: 1'b1, is_sub: 1'b0, zero_ext: 1'b1, use_carry: 1'b0};
            OP_SUBU: c = '{legal: 1'b1, is_sub: 1'b1, zero_ext: 1'b1, use_carry: 1'b0};
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_operand_shifter.sv
module acc_operand_shifter
    import acc_pkg::*;
#(
    parameter int IN_W  = OPND_W,
    parameter int OUT_W = ACC_W,
    parameter int SH_W  = SHIFT_W,
    parameter int FIX_N = FIXED_SH
) (
    input  logic [IN_W-1:0]  value,
    input  logic             zero_ext,
    input  logic [SH_W-1:0]  shamt,
    input  logic             fixed_en,
    output logic [OUT_W-1:0] shifted
);
    localparam int PAD_W = OUT_W - IN_W;
    localparam int M_W   = SH_W + 1;

    logic [OUT_W-1:0] extended;
    logic [M_W-1:0]   mag;
    logic             go_right;

    always_comb begin
        if (zero_ext) extended = {{PAD_W{1'b0}}, value};
        else          extended = {{PAD_W{value[IN_W-1]}}, value};
    end

    always_comb begin
        go_right = 1'b0;
        if (fixed_en) begin
            mag = M_W'(FIX_N);
        end else if (shamt[SH_W-1]) begin
            go_right = 1'b1;
            mag = M_W'(-$signed({shamt[SH_W-1], shamt}));
        end else begin
            mag = {1'b0, shamt};
        end
    end

    always_comb begin
        if (!go_right)     shifted = extended << mag;
        else if (zero_ext) shifted = extended >> mag;
        else               shifted = OUT_W'($signed(extended) >>> mag);
    end

endmodule

// File: rtl/acc_addsub_core.sv
module acc_addsub_core
    import acc_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd,
    input  logic         is_sub,
    input  logic         use_carry,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    logic [W-1:0] addend;
    logic         cin;
    logic [W:0]   wide;

    always_comb begin
        addend = is_sub ? ~opnd : opnd;
        if (use_carry) cin = carry_in;
        else           cin = is_sub;
        wide = {1'b0, acc_in} + {1'b0, addend} + {{W{1'b0}}, cin};
        sum       = wide[W-1:0];
        carry_out = wide[W];
    end

endmodule

// File: rtl/acc_bank.sv
module acc_bank
    import acc_pkg::*;
#(
    parameter int W = ACC_W,
    parameter int N = NUM_ACC
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_wr_t      wr,
    output logic [W-1:0] regs [N],
    output logic         carry_q
);
    for (genvar g = 0; g < N; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)                           regs[g] <= '0;
            else if (wr.we && int'(wr.idx) == g) regs[g] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        carry_q <= 1'b0;
        else if (wr.we) carry_q <= wr.carry;
    end

endmodule

// File: rtl/acc_addsub_unit.sv
module acc_addsub_unit
    import acc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [OPND_W-1:0]   operand,
    input  logic                opnd_from_acc,
    input  logic [SHIFT_W-1:0]  shift_amt,
    input  logic                shift_16,
    input  logic                src_sel,
    input  logic                dst_en,
    input  logic                dst_sel,
    output logic [ACC_W-1:0]    acc_a,
    output logic [ACC_W-1:0]    acc_b,
    output logic                carry,
    output logic [ACC_W-1:0]    result,
    output logic                result_valid
);
    op_ctrl_t          ctrl;
    logic [ACC_W-1:0]  bank_q [NUM_ACC];
    logic              carry_q;
    logic [ACC_W-1:0]  src_val;
    logic [ACC_W-1:0]  other_val;
    logic [OPND_W-1:0] raw_opnd;
    logic [ACC_W-1:0]  shifted;
    logic [ACC_W-1:0]  sum;
    logic              carry_next;
    acc_wr_t           wr;
    logic              fire;

    assign ctrl      = decode_op(acc_op_e'(op_code));
    assign fire      = op_valid && ctrl.legal;
    assign src_val   = bank_q[src_sel];
    assign other_val = bank_q[~src_sel];
    assign raw_opnd  = opnd_from_acc ? other_val[HI_MSB:HI_LSB] : operand;

    acc_operand_shifter #(
        .IN_W  (OPND_W),
        .OUT_W (ACC_W),
        .SH_W  (SHIFT_W),
        .FIX_N (FIXED_SH)
    ) u_shift (
        .value    (raw_opnd),
        .zero_ext (ctrl.zero_ext),
        .shamt    (shift_amt),
        .fixed_en (shift_16),
        .shifted  (shifted)
    );

    acc_addsub_core #(
        .W (ACC_W)
    ) u_core (
        .acc_in    (src_val),
        .opnd      (shifted),
        .is_sub    (ctrl.is_sub),
        .use_carry (ctrl.use_carry),
        .carry_in  (carry_q),
        .sum       (sum),
        .carry_out (carry_next)
    );

    always_comb begin
        wr.we    = fire;
        wr.idx   = dst_en ? dst_sel : src_sel;
        wr.data  = sum;
        wr.carry = carry_next;
    end

    acc_bank #(
        .W (ACC_W),
        .N (NUM_ACC)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .regs    (bank_q),
        .carry_q (carry_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= fire;
            if (fire) result <= sum;
        end
    end

    assign acc_a = bank_q[0];
    assign acc_b = bank_q[1];
    assign carry = carry_q;

endmodule

// File: rtl/acc_addsub_chk.sv
module acc_addsub_chk
    import acc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic             src_sel,
    input logic             dst_en,
    input logic             dst_sel,
    input logic [ACC_W-1:0] acc_a,
    input logic [ACC_W-1:0] acc_b,
    input logic             carry,
    input logic [ACC_W-1:0] result,
    input logic             result_valid
);
    logic legal_op;
    logic eff_dst;
    assign legal_op = op_code <= 3'd5;
    assign eff_dst  = dst_en ? dst_sel : src_sel;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_a == '0 && acc_b == '0 && !carry && !result_valid)); // R1

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && legal_op) |=> result_valid); // R2

    AST_DST_A_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        (op_valid && legal_op && !eff_dst) |=> (acc_a == result && $stable(acc_b))); // R5

    AST_DST_B_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        (op_valid && legal_op && eff_dst) |=> (acc_b == result && $stable(acc_a))); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(carry) && !result_valid)); // R11

    AST_RESERVED_NOOP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !legal_op) |=> ($stable(acc_a) && $stable(acc_b) && $stable(carry) && !result_valid)); // R12

endmodule

bind acc_addsub_unit acc_addsub_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .src_sel      (src_sel),
    .dst_en       (dst_en),
    .dst_sel      (dst_sel),
    .acc_a        (acc_a),
    .acc_b        (acc_b),
    .carry        (carry),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/tb_acc_addsub_unit.sv
module tb_acc_addsub_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [15:0] operand;
    logic        opnd_from_acc;
    logic [4:0]  shift_amt;
    logic        shift_16;
    logic        src_sel;
    logic        dst_en;
    logic        dst_sel;
    logic [39:0] acc_a;
    logic [39:0] acc_b;
    logic        carry;
    logic [39:0] result;
    logic        result_valid;

    int checks = 0;
    int errors = 0;

    logic [39:0] m_acc [2];
    logic        m_c;
    logic [39:0] m_res;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_addsub_unit dut (.*);

    // vector: {op[3], operand[16], shift[5], sh16, src, dst_en, dst_sel, from_acc}
    localparam logic [28:0] VEC [NVEC] = '{
        {3'd0, 16'h1234, 5'd4,     1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 add, left shift
        {3'd0, 16'h8000, 5'd0,     1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 sign extend into B
        {3'd1, 16'h0100, 5'b11100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 R5 sub, right, dest B
        {3'd4, 16'h8000, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 R8 logical right
        {3'd0, 16'h8000, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 arithmetic right
        {3'd0, 16'h00FF, 5'd3,     1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 fixed 16
        {3'd5, 16'hFFFF, 5'd0,     1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 R9 unsigned sub
        {3'd2, 16'h0001, 5'd0,     1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 add with carry
        {3'd0, 16'h0000, 5'd2,     1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 operand from B
        {3'd1, 16'h0000, 5'd0,     1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R10 R5 from A, dest A
        {3'd3, 16'h0002, 5'd0,     1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 subtract with borrow
        {3'd0, 16'h7FFF, 5'd15,    1'b0, 1'b1, 1'b1, 1'b0, 1'b0}  // R3 R5 max left shift
    };

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic model(input logic [2:0] op, input logic [15:0] v, input logic [4:0] sh,
                         input logic s16, input logic src, input logic de, input logic ds,
                         input logic fa);
        longint sv, val, acc, r;
        int n;
        logic uns;
        logic [15:0] raw;
        if (op > 3'd5) return;
        uns = (op == 3'd3 || op == 3'd4 || op == 3'd5);
        raw = fa ? m_acc[~src][31:16] : v;
        sv  = uns ? longint'(raw) : longint'($signed(raw));
        n   = s16 ? 16 : int'($signed(sh));
        if (n >= 0)   val = sv << n;
        else if (uns) val = longint'(unsigned'(sv) >> (-n));
        else          val = sv >>> (-n);
        val = val & 64'hFF_FFFF_FFFF;
        acc = longint'(m_acc[src]);
        if (op == 3'd0 || op == 3'd2 || op == 3'd4) begin
            r = acc + val + ((op == 3'd2) ? longint'(m_c) : 0);
            m_c = r[40];
        end else begin
            longint sub_v;
            sub_v = val + ((op == 3'd3) ? longint'(!m_c) : 0);
            r = acc - sub_v;
            m_c = (acc >= sub_v);
        end
        m_res = r[39:0];
        m_acc[de ? ds : src] = m_res;
    endtask

    task automatic run_op(input string req, input logic [28:0] v);
        logic [2:0] op;
        op = v[28:26];
        @(negedge clk);
        op_code = op; operand = v[25:10]; shift_amt = v[9:5]; shift_16 = v[4];
        src_sel = v[3]; dst_en = v[2]; dst_sel = v[1]; opnd_from_acc = v[0];
        op_valid = 1'b1;
        model(op, v[25:10], v[9:5], v[4], v[3], v[2], v[1], v[0]);
        @(negedge clk);
        op_valid = 1'b0;
        if (op <= 3'd5) begin
            chk({req, " result"}, result, m_res);
            chk({req, " valid (R2)"}, 40'(result_valid), 40'd1);
        end else begin
            chk({req, " valid low (R12)"}, 40'(result_valid), 40'd0);
        end
        chk({req, " acc_a"}, acc_a, m_acc[0]);
        chk({req, " acc_b"}, acc_b, m_acc[1]);
        chk({req, " carry (R9)"}, 40'(carry), 40'(m_c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; operand = '0; opnd_from_acc = 1'b0;
        shift_amt = '0; shift_16 = 1'b0; src_sel = 1'b0; dst_en = 1'b0; dst_sel = 1'b0;
        m_acc[0] = '0; m_acc[1] = '0; m_c = 1'b0; m_res = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 acc_a", acc_a, '0);
        chk("R1 acc_b", acc_b, '0);
        chk("R1 carry", 40'(carry), '0);
        chk("R1 valid", 40'(result_valid), '0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) run_op($sformatf("vec%0d", i), VEC[i]);

        // R11 idle cycles hold everything
        repeat (3) @(negedge clk);
        chk("R11 acc_a", acc_a, m_acc[0]);
        chk("R11 acc_b", acc_b, m_acc[1]);
        chk("R11 valid", 40'(result_valid), '0);

        // R12 reserved opcodes
        run_op("R12 op6", {3'd6, 16'h1111, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        run_op("R12 op7", {3'd7, 16'h2222, 5'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});

        // R9 wrap corners with literal expectations: clear A, then 0 - 1, then +1
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_acc[0] = '0; m_acc[1] = '0; m_c = 1'b0;
        run_op("R9 borrow", {3'd1, 16'h0001, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        chk("R9 borrow literal", acc_a, 40'hFF_FFFF_FFFF);
        chk("R9 carry cleared on borrow", 40'(carry), 40'd0);
        run_op("R9 carry out", {3'd0, 16'h0001, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        chk("R9 wrap literal", acc_a, 40'd0);
        chk("R9 carry set", 40'(carry), 40'd1);

        // R7 with carry 0: 10 - 3 - 1 = 6; carry 1 from the wrap above, so first make it 0
        run_op("R7 prep", {3'd4, 16'h000A, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        chk("R7 prep carry", 40'(carry), 40'd0);
        run_op("R7 borrow in", {3'd3, 16'h0003, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        chk("R7 literal", acc_a, 40'd6);

        // R4 shift_16 overrides shift_amt: 1 << 16
        run_op("R4 fixed", {3'd0, 16'h0001, 5'b10000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        chk("R4 literal", acc_b, 40'h00_0001_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule